// File: doc/BRIEF.md
# T1 Extended-Superframe Transmit Framer

The block turns a bit-serial payload into a 1544 kbit/s line stream, one line bit per clock. Each frame is 193 bits long: a single framing bit followed by 192 payload bits, taken as 24 channels of 8 bits. The framing bit is shared out over a multiframe. In the default 24-frame mode it carries the multiframe alignment word, six CRC-6 check bits and a 4 kbit/s data link. In the optional 12-frame mode it carries terminal and signalling alignment bits instead. In that mode the last bit of every channel is overwritten with a per-channel signalling bit in frames 6 and 12.

The payload source presents a bit on `pay_bit` and the framer takes it in every cycle that `pay_take` is high. The data-link source keeps a bit on `link_bit` and the framer takes it in every cycle that `link_take` pulses. The line output comes from a register, and `frame_mark` and `mfrm_mark` run with it on the same cycle.

Top module: `t1_esf_tx_framer`

## Requirements
- R1: Line bits come out one per clock with one cycle of register latency. `frame_mark` is high with the first bit of every frame, and the frames are exactly 193 bits apart. `mfrm_mark` is high together with `frame_mark` on frame 1 of each multiframe, which is 24 frames long in 24-frame mode and 12 frames long in 12-frame mode.
- R2: In 24-frame mode the framing bits of frames 4, 8, 12, 16, 20 and 24 carry the alignment word 0,0,1,0,1,1 in that frame order.
- R3: In 24-frame mode the framing bits of frames 2, 6, 10, 14, 18 and 22 carry the CRC-6 of the previous multiframe, most significant remainder bit first. The generator is x^6+x+1. The CRC covers every line bit of that multiframe in transmit order, with each framing bit counted as 1, and the remainder starts from zero.
- R4: In 24-frame mode `link_take` is high for exactly the framing-bit cycle of each odd-numbered frame. The `link_bit` value present in that cycle is the framing bit on the line in the next cycle.
- R5: `pay_take` is high in the 192 payload cycles of every frame and low in the framing-bit cycle. The `pay_bit` value taken in a cycle appears on `line_bit` in the next cycle, unless R7 overwrites it.
- R6: In 12-frame mode (`rb_mode`=1) the framing bits of frames 1,3,5,7,9,11 are 1,0,1,0,1,0. The framing bits of frames 2,4,6,8,10,12 are 0,0,1,1,1,0. `link_take` stays low.
- R7: In 12-frame mode, payload bit 8c+8 of frame 6 (the last bit of channel c, c=0..23, counting payload bits from 1) is sent as `sig_a[c]`. The same bit of frame 12 is sent as `sig_b[c]`. The payload bit taken in that cycle is dropped. In 24-frame mode no payload bit is overwritten.
- R8: `rb_mode` is sampled only while reset is high and in the cycle that carries the last bit of a multiframe. A change at any other time has no effect until the next multiframe.
- R9: A synchronous active-high reset forces `line_bit`, `frame_mark`, `mfrm_mark`, `pay_take` and `link_take` low. After reset the framer starts at frame 1, and it sends all-zero CRC bits in the first multiframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst | input | 1 | Synchronous reset, active high |
| rb_mode | input | 1 | 0: 24-frame CRC/data-link mode, 1: 12-frame robbed-bit mode |
| pay_bit | input | 1 | Serial payload bit |
| pay_take | output | 1 | Payload bit is taken this cycle |
| link_bit | input | 1 | Data-link bit |
| link_take | output | 1 | Data-link bit is taken this cycle |
| sig_a | input | 24 | Per-channel signalling bit A for frame 6 |
| sig_b | input | 24 | Per-channel signalling bit B for frame 12 |
| line_bit | output | 1 | Serial line output |
| frame_mark | output | 1 | High with the first bit of each frame |
| mfrm_mark | output | 1 | High with the first bit of each multiframe |

## Verification
Two events fall in the same cycle: the closing of the CRC over the last bit of a multiframe and the sampling of `rb_mode` for the next one. The bench provokes this by toggling `rb_mode` in the middle of a multiframe and again in exactly the last-bit cycle. Each multiframe length then differs from the one before, and the CRC of a short 12-frame multiframe must come out in the 24-frame multiframe that follows it. The bench judges each line bit against a reference that stores the whole multiframe and divides it by long division. It tracks the mode change on its own, so a framer that closes the CRC on the wrong frame count, or switches mode early, disagrees at once.

// File: rtl/t1fr_pkg.sv
package t1fr_pkg;

  localparam int CRC_W = 6;
  // x^6 + x + 1, low-order taps only
  localparam logic [CRC_W-1:0] CRC_TAPS = 6'b000011;

  // alignment words, leftmost bit sent first
  localparam logic [5:0] ESF_ALIGN = 6'b001011;
  localparam logic [5:0] RB_TERM   = 6'b101010;
  localparam logic [5:0] RB_SIGAL  = 6'b001110;

  typedef enum logic {MODE_ESF = 1'b0, MODE_RB = 1'b1} mf_mode_e;

  // one serial step of the CRC division
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] acc,
                                                input logic d);
    logic fb;
    fb = acc[CRC_W-1] ^ d;
    return {acc[CRC_W-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
  endfunction

  // framing bit in 24-frame mode, frm = 0-based frame index
  function automatic logic esf_fbit(input logic [4:0] frm,
                                    input logic [CRC_W-1:0] crc,
                                    input logic link);
    logic [2:0] k;
    k = frm[4:2];
    if (!frm[0])            return link;              // odd frame numbers
    else if (frm[1:0] == 2'd1) return crc[3'd5 - k]; // frames 2,6,...
    else                    return ESF_ALIGN[3'd5 - k]; // frames 4,8,...
  endfunction

  // framing bit in 12-frame mode
  function automatic logic rb_fbit(input logic [4:0] frm);
    logic [2:0] k;
    k = frm[3:1];
    if (!frm[0]) return RB_TERM[3'd5 - k];
    else         return RB_SIGAL[3'd5 - k];
  endfunction

endpackage

// File: rtl/t1fr_seq.sv
module t1fr_seq #(
  parameter int FRAME_BITS = 193,
  parameter int MF_LONG    = 24,
  parameter int MF_SHORT   = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_in,
  output logic [7:0] bit_pos,
  output logic [4:0] frm,
  output logic       mode_q,
  output logic       fslot,
  output logic       mf_last
);
  localparam logic [7:0] LAST_BIT = 8'(FRAME_BITS - 1);
  localparam logic [4:0] LAST_L   = 5'(MF_LONG - 1);
  localparam logic [4:0] LAST_S   = 5'(MF_SHORT - 1);

  logic frame_end;
  logic [4:0] last_frm;

  assign last_frm  = mode_q ? LAST_S : LAST_L;
  assign frame_end = (bit_pos == LAST_BIT);
  assign mf_last   = frame_end && (frm == last_frm);
  assign fslot     = (bit_pos == 8'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_pos <= '0;
      frm     <= '0;
      mode_q  <= mode_in;
    end else if (frame_end) begin
      bit_pos <= '0;
      if (mf_last) begin
        frm    <= '0;
        mode_q <= mode_in;
      end else begin
        frm <= frm + 5'd1;
      end
    end else begin
      bit_pos <= bit_pos + 8'd1;
    end
  end

  // R8: mode only moves across a multiframe boundary
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !mf_last |=> $stable(mode_q));
  // R1: frame index never passes the multiframe length
  a_r1_frm_range: assert property (@(posedge clk) disable iff (rst)
    frm <= last_frm);

endmodule

// File: rtl/t1fr_crc.sv
module t1fr_crc
  import t1fr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             d_bit,
  input  logic             mf_last,
  output logic [CRC_W-1:0] crc_hold
);
  logic [CRC_W-1:0] acc;
  logic [CRC_W-1:0] acc_nx;

  assign acc_nx = crc_step(acc, d_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      crc_hold <= '0;
    end else if (mf_last) begin
      crc_hold <= acc_nx;
      acc      <= '0;
    end else begin
      acc <= acc_nx;
    end
  end

  // R3: the sent remainder only changes at a multiframe boundary
  a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !mf_last |=> $stable(crc_hold));
  // R3: the running remainder restarts at every boundary
  a_r3_acc_restart: assert property (@(posedge clk) disable iff (rst)
    mf_last |=> (acc == '0));

endmodule

// File: rtl/t1fr_mux.sv
module t1fr_mux
  import t1fr_pkg::*;
#(
  parameter int CHANS = 24
) (
  input  logic             mode_q,
  input  logic [7:0]       bit_pos,
  input  logic [4:0]       frm,
  input  logic             fslot,
  input  logic [CRC_W-1:0] crc_hold,
  input  logic             link_bit,
  input  logic             pay_bit,
  input  logic [CHANS-1:0] sig_a,
  input  logic [CHANS-1:0] sig_b,
  output logic             nxt_bit,
  output logic             crc_in
);
  logic [4:0] chan;
  logic       chan_lsb;
  logic       fbit;
  logic       pay_sel;

  assign chan     = bit_pos[7:3] - 5'd1;
  assign chan_lsb = (bit_pos[2:0] == 3'd0) && !fslot;

  always_comb begin
    fbit = (mode_q == MODE_RB) ? rb_fbit(frm) : esf_fbit(frm, crc_hold, link_bit);
    pay_sel = pay_bit;
    if (mode_q == MODE_RB && chan_lsb) begin
      if (frm == 5'd5)       pay_sel = sig_a[chan];
      else if (frm == 5'd11) pay_sel = sig_b[chan];
    end
    nxt_bit = fslot ? fbit : pay_sel;
    crc_in  = fslot ? 1'b1 : pay_sel;
  end

endmodule

// File: rtl/t1_esf_tx_framer.sv
module t1_esf_tx_framer #(
  parameter int CHANS = 24,
  parameter int CH_BITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rb_mode,
  input  logic             pay_bit,
  output logic             pay_take,
  input  logic             link_bit,
  output logic             link_take,
  input  logic [CHANS-1:0] sig_a,
  input  logic [CHANS-1:0] sig_b,
  output logic             line_bit,
  output logic             frame_mark,
  output logic             mfrm_mark
);
  import t1fr_pkg::*;

  localparam int FRAME_BITS = CHANS * CH_BITS + 1;

  logic [7:0]       bit_pos;
  logic [4:0]       frm;
  logic             mode_q;
  logic             fslot;
  logic             mf_last;
  logic [CRC_W-1:0] crc_hold;
  logic             nxt_bit;
  logic             crc_in;

  t1fr_seq #(.FRAME_BITS(FRAME_BITS), .MF_LONG(24), .MF_SHORT(12)) seq_i (
    .clk(clk), .rst(rst), .mode_in(rb_mode),
    .bit_pos(bit_pos), .frm(frm), .mode_q(mode_q),
    .fslot(fslot), .mf_last(mf_last)
  );

  t1fr_crc crc_i (
    .clk(clk), .rst(rst), .d_bit(crc_in), .mf_last(mf_last), .crc_hold(crc_hold)
  );

  t1fr_mux #(.CHANS(CHANS)) mux_i (
    .mode_q(mode_q), .bit_pos(bit_pos), .frm(frm), .fslot(fslot),
    .crc_hold(crc_hold), .link_bit(link_bit), .pay_bit(pay_bit),
    .sig_a(sig_a), .sig_b(sig_b), .nxt_bit(nxt_bit), .crc_in(crc_in)
  );

  assign pay_take  = !rst && !fslot;
  assign link_take = !rst && fslot && (mode_q == MODE_ESF) && !frm[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      line_bit   <= 1'b0;
      frame_mark <= 1'b0;
      mfrm_mark  <= 1'b0;
    end else begin
      line_bit   <= nxt_bit;
      frame_mark <= fslot;
      mfrm_mark  <= fslot && (frm == 5'd0);
    end
  end

  // R1: a multiframe start is always a frame start
  a_r1_mf_in_frame: assert property (@(posedge clk) disable iff (rst)
    mfrm_mark |-> frame_mark);
  // R5: the framing slot took no payload
  a_r5_gap_at_frame: assert property (@(posedge clk) disable iff (rst)
    frame_mark |-> !$past(pay_take));
  // R4: data link is only taken outside payload
  a_r4_link_not_payload: assert property (@(posedge clk) disable iff (rst)
    link_take |-> !pay_take);
  // R4 / R6: link pulses are single-cycle
  a_r4_link_pulse: assert property (@(posedge clk) disable iff (rst)
    link_take |=> !link_take);

endmodule

// File: tb/t1_esf_tx_framer_tb_top.sv
module t1_esf_tx_framer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rb_mode = 1'b0;
  logic pay_bit = 1'b0;
  logic link_bit = 1'b0;
  logic [23:0] sig_a = '0;
  logic [23:0] sig_b = '0;
  logic pay_take, link_take, line_bit, frame_mark, mfrm_mark;

  always #4 clk = ~clk;  // 125 MHz

  t1_esf_tx_framer dut_i (
    .clk(clk), .rst(rst), .rb_mode(rb_mode), .pay_bit(pay_bit), .pay_take(pay_take),
    .link_bit(link_bit), .link_take(link_take), .sig_a(sig_a), .sig_b(sig_b),
    .line_bit(line_bit), .frame_mark(frame_mark), .mfrm_mark(mfrm_mark)
  );

  int vectors = 0;
  int fails = 0;

  // reference model state
  int  m_pos, m_frm, m_n;
  bit  m_mode, m_first, m_switched;
  logic [5:0] m_crc;
  bit  mfb [0:4637];
  logic e_line = 0, e_frm = 0, e_mf = 0;
  string e_tag = "R9";

  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] ref_crc(int n);
    bit w [0:4637];
    logic [5:0] r;
    for (int i = 0; i < n + 6; i++) w[i] = (i < n) ? mfb[i] : 1'b0;
    for (int i = 0; i < n; i++)
      if (w[i]) begin
        w[i] = 1'b0; w[i+5] = ~w[i+5]; w[i+6] = ~w[i+6];
      end
    for (int j = 0; j < 6; j++) r[5-j] = w[n+j];
    return r;
  endfunction

  function automatic logic pat_bit(logic [5:0] p, int k);
    return p[5-k];
  endfunction

  task automatic model_reset();
    m_pos = 0; m_frm = 0; m_n = 0; m_crc = '0;
    m_mode = rb_mode; m_first = 1; m_switched = 0;
  endtask

  // one cycle: compare last edge, drive new inputs, predict next edge
  task automatic tick(bit nrst, bit nmode);
    int fn;
    logic b;
    @(negedge clk);
    chk({e_tag, " line_bit"}, line_bit, e_line);
    chk("R1 frame_mark", frame_mark, e_frm);
    chk("R1 mfrm_mark", mfrm_mark, e_mf);
    chk(rst ? "R9 pay_take" : "R5 pay_take", pay_take, !rst && m_pos != 0);
    chk(rst ? "R9 link_take" : (m_mode ? "R6 link_take" : "R4 link_take"), link_take,
        !rst && m_pos == 0 && !m_mode && (m_frm % 2 == 0));
    rst = nrst;
    rb_mode = nmode;
    pay_bit = 1'($urandom);
    link_bit = 1'($urandom);
    if (($urandom % 300) == 0) begin sig_a = 24'($urandom); sig_b = 24'($urandom); end
    if (rst) begin
      e_line = 0; e_frm = 0; e_mf = 0; e_tag = "R9";
      model_reset();
    end else begin
      fn = m_frm + 1;
      e_frm = (m_pos == 0);
      e_mf = (m_pos == 0) && (m_frm == 0);
      if (m_pos == 0) begin
        if (m_mode) begin
          b = (fn % 2 == 1) ? pat_bit(6'b101010, (fn - 1) / 2) : pat_bit(6'b001110, fn / 2 - 1);
          e_tag = "R6";
        end else if (fn % 2 == 1) begin
          b = link_bit; e_tag = "R4";
        end else if (fn % 4 == 2) begin
          b = m_crc[5 - (fn - 2) / 4]; e_tag = m_first ? "R9 crc" : "R3";
        end else begin
          b = pat_bit(6'b001011, fn / 4 - 1); e_tag = "R2";
        end
        if (m_switched) e_tag = {"R8 ", e_tag};
        mfb[m_n] = 1'b1;
      end else begin
        b = pay_bit; e_tag = "R5";
        if (m_mode && (m_pos % 8 == 0) && (fn == 6 || fn == 12)) begin
          b = (fn == 6) ? sig_a[m_pos / 8 - 1] : sig_b[m_pos / 8 - 1];
          e_tag = "R7";
        end
        mfb[m_n] = b;
      end
      e_line = b;
      m_n++;
      if (m_pos == 192) begin
        m_pos = 0;
        if (m_frm == (m_mode ? 11 : 23)) begin
          m_frm = 0;
          m_crc = ref_crc(m_n);
          m_n = 0;
          m_first = 0;
          m_switched = (m_mode != rb_mode);
          m_mode = rb_mode;
        end else m_frm++;
      end else m_pos++;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7177));
    model_reset();
    repeat (3) tick(1, 0);
    // R9 reset state seen at the ports
    @(negedge clk);
    chk("R9 reset line_bit", line_bit, 1'b0);
    chk("R9 reset pay_take", pay_take, 1'b0);
    // 24-frame mode, three multiframes
    for (int i = 0; i < 3 * 4632; i++) tick(0, 0);
    // R8: mode raised mid-multiframe, applies only at next boundary
    for (int i = 0; i < 4632; i++) tick(0, 1);
    for (int i = 0; i < 2 * 2316; i++) tick(0, 1);
    // drop mode mid-multiframe, raise again before the last bit
    for (int i = 0; i < 1000; i++) tick(0, 0);
    for (int i = 0; i < 1315; i++) tick(0, 1);
    tick(0, 0);  // last-bit cycle samples 24-frame mode
    for (int i = 0; i < 2 * 4632; i++) tick(0, 0);
    // R9: reset in the middle of a frame, restart with zero CRC
    for (int i = 0; i < 777; i++) tick(0, 0);
    repeat (2) tick(1, 0);
    for (int i = 0; i < 2 * 4632 + 10; i++) tick(0, 0);
    // 12-frame run entered through reset
    repeat (2) tick(1, 1);
    for (int i = 0; i < 2 * 2316 + 5; i++) tick(0, 1);
    tick(0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule